// File: doc/BRIEF.md
# Group Interrupt Backlog Counter Port

This block sits on a simple register bus and gives software atomic access to per-priority backlog counters. There are two counter tables, one for group entries and one for crowd entries. Each entry holds eight counters, one per interrupt priority. The address picks a table, an entry and, in its low twelve bits, an operation and a priority.

Every access is a read-modify-write that hands back the counter value from before the access. A byte store adjusts the counter by the stored byte. A halfword load adjusts it by one. The operation can be an increment, a decrement or a plain read. A decrement can never take a counter below zero, and an increment never wraps past the top of the counter's range.

The entry valid bits come from the entry tables outside this block and are presented as input vectors. After reset the block zeroes its whole counter memory before it accepts the first access.

Top module: `grp_backlog_port`

## Requirements
- R1: While reset is high and during the clear sweep after it, `req_ready` and `resp_valid` are low. When `req_ready` first rises, every counter reads zero.
- R2: Address decode works as follows:
  - offset bits 11:10 carry the operation: 00 increments, 01 decrements, 10 and 11 read without change;
  - offset bits 6:4 carry the priority;
  - address bit ADDR_W-1 selects the crowd table (1) or the group table (0);
  - `addr[ADDR_W-2:PAGE_SHIFT]` is the entry index;
  - all other address bits are ignored.
- R3: A store with `req_size` 1 uses `req_wdata` as the amount. Its response carries the counter value from before the store.
- R4: A load with `req_size` 2 uses an amount of one. Its response carries the old counter value, zero-extended.
- R5: A store whose size is not 1, or a load whose size is not 2, changes no counter and responds with all ones.
- R6: A decrement whose amount is at least the current count leaves the counter at zero.
- R7: An increment that would exceed 2^CNT_W-1 leaves the counter at 2^CNT_W-1.
- R8: An access to an entry index at or above DEPTH, or to an entry whose valid bit is low, changes no counter and responds with all ones.
- R9: A read operation leaves the counter unchanged.
- R10: Response timing:
  - for an accepted well-formed access, `req_ready` is low in the next cycle and `resp_valid` is high two cycles after acceptance;
  - for a rejected access, `resp_valid` is high one cycle after acceptance;
  - the access that follows sees the updated counter.
- R11: Counters are independent across the two tables, entries and priorities.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block can accept an access this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 4 | Access width in bytes |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | 8 | Store byte (the amount) |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | DATA_W | Old counter value, or all ones on error |
| grp_valid | input | DEPTH | Valid bit per group entry |
| crd_valid | input | DEPTH | Valid bit per crowd entry |

## Verification
The bench drives decrements larger than the count and at exactly zero. A design that wraps instead of flooring at zero would return a huge count on the next read. Repeated maximum-byte increments push a counter past its ceiling: a design that wraps would read back a small value, and one that returns the new value rather than the old would be off by the amount. Wrong access sizes, invalid entries, out-of-range indices and junk address bits are each followed by a read of the counter they could have touched, which catches any change that leaked through. Back-to-back accesses to one counter expose a stale-read hazard in the write-back path.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int OP_LSB   = 10;
  localparam int PRIO_LSB = 4;
  localparam int PRIO_W   = 3;

  typedef enum logic [1:0] {
    OP_INC = 2'b00,
    OP_DEC = 2'b01,
    OP_RDA = 2'b10,
    OP_RDB = 2'b11
  } bp_op_e;

  typedef enum logic [1:0] {
    ST_CLR  = 2'd0,
    ST_IDLE = 2'd1,
    ST_MOD  = 2'd2
  } bp_state_e;
endpackage

// File: rtl/bp_decode.sv
module bp_decode
  import bp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 16,
  parameter int DEPTH      = 16,
  parameter int IDX_W      = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic [3:0]        size,
  input  logic [DEPTH-1:0]  grp_valid,
  input  logic [DEPTH-1:0]  crd_valid,
  output logic              ok,
  output logic [1:0]        op,
  output logic [PRIO_W-1:0] prio,
  output logic              win,
  output logic [IDX_W-1:0]  idx
);
  localparam int FIELD_W = ADDR_W - 1 - PAGE_SHIFT;

  logic [FIELD_W-1:0] field;
  logic               in_range;
  logic               size_ok;
  logic               entry_ok;
  logic               unused_addr_bits;

  assign field    = addr[ADDR_W-2:PAGE_SHIFT];
  assign win      = addr[ADDR_W-1];
  assign idx      = field[IDX_W-1:0];
  assign op       = addr[OP_LSB+1:OP_LSB];
  assign prio     = addr[PRIO_LSB +: PRIO_W];
  assign in_range = field < FIELD_W'(DEPTH);
  assign size_ok  = write ? (size == 4'd1) : (size == 4'd2);

  always_comb begin
    entry_ok = 1'b0;
    if (in_range) entry_ok = win ? crd_valid[idx] : grp_valid[idx];
  end

  assign ok = size_ok && entry_ok;

  assign unused_addr_bits = ^{addr[PRIO_LSB-1:0], addr[OP_LSB-1:PRIO_LSB+PRIO_W],
                              addr[PAGE_SHIFT-1:OP_LSB+2]};
endmodule

// File: rtl/bp_update.sv
module bp_update #(
  parameter int CNT_W = 24
) (
  input  logic [CNT_W-1:0] old_cnt,
  input  logic [1:0]       op,
  input  logic [7:0]       amount,
  output logic [CNT_W-1:0] new_cnt,
  output logic             wr
);
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] amt_ext;

  assign amt_ext = CNT_W'(amount);
  assign sum     = {1'b0, old_cnt} + {1'b0, amt_ext};
  assign wr      = !op[1];

  always_comb begin
    new_cnt = old_cnt;
    if (op == 2'b00) begin
      new_cnt = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    end else if (op == 2'b01) begin
      new_cnt = (old_cnt > amt_ext) ? (old_cnt - amt_ext) : '0;
    end
  end
endmodule

// File: rtl/bp_ram.sv
module bp_ram #(
  parameter int AW = 8,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/grp_backlog_port.sv
module grp_backlog_port
  import bp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int PAGE_SHIFT = 16,
  parameter int DEPTH      = 16,
  parameter int CNT_W      = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [3:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  input  logic [DEPTH-1:0]  grp_valid,
  input  logic [DEPTH-1:0]  crd_valid
);
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int RAM_AW = 1 + IDX_W + PRIO_W;

  bp_state_e          state;
  logic [RAM_AW-1:0]  clr_ptr;
  logic [RAM_AW-1:0]  mod_addr;
  logic [1:0]         op_q;
  logic [7:0]         amt_q;

  logic               dec_ok;
  logic [1:0]         dec_op;
  logic [PRIO_W-1:0]  dec_prio;
  logic               dec_win;
  logic [IDX_W-1:0]   dec_idx;
  logic               accept;

  logic               ram_we;
  logic [RAM_AW-1:0]  ram_waddr;
  logic [CNT_W-1:0]   ram_wdata;
  logic [CNT_W-1:0]   ram_rdata;
  logic [CNT_W-1:0]   upd_new;
  logic               upd_wr;

  bp_decode #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .DEPTH(DEPTH), .IDX_W(IDX_W)
  ) u_decode (
    .addr(req_addr), .write(req_write), .size(req_size),
    .grp_valid(grp_valid), .crd_valid(crd_valid),
    .ok(dec_ok), .op(dec_op), .prio(dec_prio), .win(dec_win), .idx(dec_idx)
  );

  bp_update #(.CNT_W(CNT_W)) u_update (
    .old_cnt(ram_rdata), .op(op_q), .amount(amt_q),
    .new_cnt(upd_new), .wr(upd_wr)
  );

  bp_ram #(.AW(RAM_AW), .DW(CNT_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr({dec_win, dec_idx, dec_prio}), .rdata(ram_rdata)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = mod_addr;
    ram_wdata = upd_new;
    if (state == ST_CLR) begin
      ram_we    = 1'b1;
      ram_waddr = clr_ptr;
      ram_wdata = '0;
    end else if (state == ST_MOD) begin
      ram_we = upd_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_CLR;
      clr_ptr    <= '0;
      mod_addr   <= '0;
      op_q       <= 2'b10;
      amt_q      <= '0;
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        ST_CLR: begin
          clr_ptr <= clr_ptr + 1'b1;
          if (&clr_ptr) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (req_valid) begin
            if (dec_ok) begin
              mod_addr <= {dec_win, dec_idx, dec_prio};
              op_q     <= dec_op;
              amt_q    <= req_write ? req_wdata : 8'd1;
              state    <= ST_MOD;
            end else begin
              resp_valid <= 1'b1;
              resp_data  <= '1;
            end
          end
        end
        ST_MOD: begin
          resp_valid <= 1'b1;
          resp_data  <= DATA_W'(ram_rdata);
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: nothing is accepted or answered during the clear sweep
  a_r1_clear_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CLR) |-> (!req_ready && !resp_valid));

  // R10: a good access blocks the port next cycle and answers one cycle later
  a_r10_ok_latency: assert property (@(posedge clk) disable iff (rst)
    (accept && dec_ok) |=> (!req_ready && !resp_valid));
  a_r10_ok_resp: assert property (@(posedge clk) disable iff (rst)
    (accept && dec_ok) |-> ##2 resp_valid);

  // R8 / R5: a rejected access answers with all ones in the next cycle
  a_r8_err_resp: assert property (@(posedge clk) disable iff (rst)
    (accept && !dec_ok) |=> (resp_valid && (resp_data == {DATA_W{1'b1}})));

  // R6: a decrement write-back never exceeds the old count
  a_r6_dec_floor: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MOD && op_q == OP_DEC) |-> (ram_wdata <= ram_rdata));

  // R7: an increment write-back never falls below the old count
  a_r7_inc_ceiling: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MOD && op_q == OP_INC) |-> (ram_wdata >= ram_rdata));

  // R9: a read operation never writes the counter memory
  a_r9_read_no_write: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MOD && op_q[1]) |-> !ram_we);
endmodule

// File: tb/grp_backlog_port_test.sv
module grp_backlog_port_test;
  localparam int AW    = 32;
  localparam int DW    = 32;
  localparam int DEP   = 16;
  localparam int CW    = 10;
  localparam int MAXC  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [3:0]    req_size = 4'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_wdata = '0;
  logic          resp_valid;
  logic [DW-1:0] resp_data;
  logic [DEP-1:0] grp_valid = '1;
  logic [DEP-1:0] crd_valid = '1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int mdl [2][DEP][8];
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  always #5 clk = ~clk;

  grp_backlog_port #(
    .ADDR_W(AW), .DATA_W(DW), .PAGE_SHIFT(16), .DEPTH(DEP), .CNT_W(CW)
  ) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_data(resp_data),
    .grp_valid(grp_valid), .crd_valid(crd_valid)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: pops the scoreboard on every response
  always @(negedge clk) begin
    if (!rst && resp_valid) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected response", 32'h1, 32'h0);
      end else begin
        check(tag_q.pop_front(), resp_data, exp_q.pop_front());
      end
    end
  end

  // driver: computes the expected response and issues one access
  task automatic access(input bit wr, input int size, input bit win, input int idx,
                        input int op, input int prio, input int wd, input string tag,
                        input logic [AW-1:0] junk = '0);
    bit ok;
    int old, amt;
    logic [DW-1:0] expv;
    ok = (wr ? size == 1 : size == 2) && idx < DEP &&
         (win ? crd_valid[idx] : grp_valid[idx]);
    if (!ok) expv = '1;
    else begin
      old  = mdl[win][idx][prio];
      expv = DW'(old);
      amt  = wr ? wd : 1;
      if (op == 0) mdl[win][idx][prio] = (old + amt > MAXC) ? MAXC : old + amt;
      else if (op == 1) mdl[win][idx][prio] = (old > amt) ? old - amt : 0;
    end
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_size  = 4'(size);
    req_wdata = 8'(wd);
    req_addr  = (AW'(win) << (AW-1)) | (AW'(idx) << 16) | (AW'(op) << 10) |
                (AW'(prio) << 4) | junk;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < DEP; i++)
        for (int p = 0; p < 8; p++) mdl[w][i][p] = 0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", DW'(req_ready), 0);
    check("R1 resp in reset", DW'(resp_valid), 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    check("R1 ready during clear", DW'(req_ready), 0);
    while (!req_ready) @(negedge clk);

    // R1 counters cleared
    access(0, 2, 0, 3, 2, 0, 0, "R1 zero group");
    access(0, 2, 1, 5, 3, 7, 0, "R1 zero crowd");

    // R3 store increment, R4 load increment, R9 read
    access(1, 1, 0, 3, 0, 2, 7, "R3 store inc old");
    access(0, 2, 0, 3, 0, 2, 0, "R4 load inc old");
    access(0, 2, 0, 3, 3, 2, 0, "R9 read after inc");
    access(0, 2, 0, 3, 2, 2, 0, "R9 read unchanged");

    // R6 decrement floors at zero
    access(1, 1, 0, 3, 1, 2, 9, "R6 dec past zero");
    access(0, 2, 0, 3, 2, 2, 0, "R6 reads zero");
    access(0, 2, 0, 3, 1, 2, 0, "R6 dec at zero");
    access(1, 1, 0, 3, 0, 2, 4, "R6 refill");
    access(1, 1, 0, 3, 1, 2, 4, "R6 dec exact");
    access(0, 2, 0, 3, 2, 2, 0, "R6 exact gives zero");

    // R11 independence
    access(1, 1, 1, 3, 0, 2, 5, "R11 crowd inc");
    access(0, 2, 0, 3, 2, 2, 0, "R11 group untouched");
    access(0, 2, 1, 3, 2, 3, 0, "R11 other prio");
    access(0, 2, 1, 4, 2, 2, 0, "R11 other entry");
    access(0, 2, 1, 3, 2, 2, 0, "R11 crowd value");

    // R5 wrong sizes
    access(1, 2, 1, 3, 0, 2, 50, "R5 store size2");
    access(1, 4, 1, 3, 1, 2, 50, "R5 store size4");
    access(0, 1, 1, 3, 0, 2, 0, "R5 load size1");
    access(0, 4, 1, 3, 0, 2, 0, "R5 load size4");
    access(0, 2, 1, 3, 2, 2, 0, "R5 no change");

    // R8 invalid and out-of-range entries
    grp_valid[4] = 1'b0;
    access(1, 1, 0, 4, 0, 1, 30, "R8 invalid store");
    access(0, 2, 0, 4, 0, 1, 0, "R8 invalid load");
    grp_valid[4] = 1'b1;
    access(0, 2, 0, 4, 2, 1, 0, "R8 no change");
    access(1, 1, 0, 20, 0, 1, 30, "R8 out of range");

    // R2 junk offset bits ignored, priority field honoured
    access(1, 1, 0, 6, 0, 5, 11, "R2 junk store", 32'h0000_F38F);
    access(0, 2, 0, 6, 2, 5, 0, "R2 read prio5");
    access(0, 2, 0, 6, 2, 4, 0, "R2 prio4 clean");

    // R7 increment ceiling
    for (int k = 0; k < 5; k++) access(1, 1, 1, 1, 0, 0, 255, "R7 inc climb");
    access(0, 2, 1, 1, 0, 0, 0, "R7 inc at max");
    access(0, 2, 1, 1, 2, 0, 0, "R7 stays max");

    // R10 latency of a good access and of a rejected one
    access(0, 2, 0, 9, 2, 0, 0, "R10 timed read");
    check("R10 ready low", DW'(req_ready), 0);
    check("R10 no early resp", DW'(resp_valid), 0);
    @(negedge clk);
    check("R10 resp at two", DW'(resp_valid), 1);
    access(0, 3, 0, 9, 2, 0, 0, "R10 timed error");
    check("R10 err resp at one", DW'(resp_valid), 1);

    repeat (6) @(negedge clk);
    check("R10 scoreboard drained", DW'(exp_q.size()), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule